// File: doc/BRIEF.md
# Row-Column Decoded Read/Write Memory

This block is a small read/write memory of eight 4-bit words. The words are not held as a flat word array. They sit in four physical rows, and each row is 8 bits wide, so every row holds two words side by side. The upper two address bits drive a one-hot row decoder that enables a single row line. The lowest address bit drives a one-hot column decoder that chooses which 4-bit half of that row is attached to the data bus.

A single bidirectional 4-bit bus carries data both ways. When the chip is selected in read mode, the addressed half-row drives the bus combinationally through an enable-controlled tristate driver. In every other case the driver is off and the bus floats, so an external agent can drive write data onto it. Writes take effect on the rising clock edge. Both decoder outputs are brought out as observation ports.

Top module: `rowcol_ram`

## Requirements
- R1: A synchronous active-high reset clears every stored bit to 0. While reset is high the bus driver is off and both decoder outputs are all zero when chip select is low.
- R2: With chip select high, `row_sel` is one-hot, and bit r is set when address bits [2:1] equal r.
- R3: With chip select high, `col_sel` is one-hot. Address bit 0 = 0 sets `col_sel[0]` (row bits 3:0) and address bit 0 = 1 sets `col_sel[1]` (row bits 7:4).
- R4: With chip select high and `rd_nwr` = 0 at a rising clock edge, the bus value is stored at the addressed word. The other half of the same row and all other rows keep their contents.
- R5: With chip select high and `rd_nwr` = 1, `bus_oe` is 1 and the bus shows the addressed word in the same cycle, with no clock edge in between.
- R6: With chip select low, no write happens whatever the bus and `rd_nwr` carry, `bus_oe` is 0, and `row_sel` and `col_sel` are all zero.
- R7: With `rd_nwr` = 0, `bus_oe` is 0 and the block leaves the bus undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears storage |
| addr | input | 3 | Word address: [2:1] selects the row, [0] selects the half |
| cs | input | 1 | Chip select, active high |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| data | inout | 4 | Shared bidirectional data bus |
| bus_oe | output | 1 | High while the block drives `data` |
| row_sel | output | 4 | One-hot row decoder lines |
| col_sel | output | 2 | One-hot column decoder lines |

## Verification
The write assertions assume that the bus holds a defined value whenever a write is requested, meaning some agent other than the block drives it. The bench meets this by enabling its own bus driver whenever `rd_nwr` is 0, and it never drives while a read is selected, so the two drivers never overlap. Inputs change only just after a rising edge and are held stable for the whole cycle, which keeps the combinational read path and the decoder properties free of mid-cycle glitches. The reference model is a plain eight-entry word array in the bench, and all eight addresses are covered, including both halves of each row.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  parameter int unsigned RCR_ADDR_W = 3;
  parameter int unsigned RCR_DATA_W = 4;
  parameter int unsigned RCR_COL_AW = 1;
endpackage

// File: rtl/rcr_onehot_dec.sv
module rcr_onehot_dec #(
  parameter int unsigned IN_W = 2,
  localparam int unsigned OUT_N = 1 << IN_W
) (
  input  logic              en,
  input  logic [IN_W-1:0]   idx,
  output logic [OUT_N-1:0]  sel
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign sel[i] = en && (idx == IN_W'(i));
  end

  always_comb begin
    assert ($onehot0(sel)) else $error("AST_DEC_ONEHOT"); // R2
  end
endmodule

// File: rtl/rcr_cell_array.sv
module rcr_cell_array #(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned COLS   = 2,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned ROW_W = DATA_W * COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ROWS-1:0]   row_en,
  input  logic [COLS-1:0]   col_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [ROW_W-1:0]  rd_row
);
  logic [ROWS-1:0][ROW_W-1:0] cells;

  // Only the cells at the crossing of the live row line and live column line load.
  always_ff @(posedge clk) begin
    if (rst) begin
      cells <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          if (row_en[r] && col_en[c]) begin
            cells[r][c*DATA_W +: DATA_W] <= wdata;
          end
        end
      end
    end
  end

  // Wired-OR of the enabled row onto the shared row bitlines.
  always_comb begin
    rd_row = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_en[r]) rd_row = rd_row | cells[r];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cells == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (row_en == '0) |=> $stable(cells)); // R6

  for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
    for (genvar c = 0; c < COLS; c++) begin : g_col_chk
      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && row_en[r] && col_en[c]) |=>
          (cells[r][c*DATA_W +: DATA_W] == $past(wdata))); // R4
      AST_OTHER_ROW_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!row_en[r]) |=> $stable(cells[r])); // R4
    end
  end
endmodule

// File: rtl/rcr_col_steer.sv
module rcr_col_steer #(
  parameter int unsigned COLS   = 2,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned ROW_W = DATA_W * COLS
) (
  input  logic [ROW_W-1:0]  row_data,
  input  logic [COLS-1:0]   col_en,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    word = '0;
    for (int c = 0; c < COLS; c++) begin
      if (col_en[c]) word = word | row_data[c*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/rowcol_ram.sv
module rowcol_ram
  import rcr_pkg::*;
#(
  parameter int unsigned ADDR_W = RCR_ADDR_W,
  parameter int unsigned DATA_W = RCR_DATA_W,
  parameter int unsigned COL_AW = RCR_COL_AW,
  localparam int unsigned ROW_AW = ADDR_W - COL_AW,
  localparam int unsigned ROWS   = 1 << ROW_AW,
  localparam int unsigned COLS   = 1 << COL_AW,
  localparam int unsigned ROW_W  = DATA_W * COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs,
  input  logic              rd_nwr,
  inout  wire  [DATA_W-1:0] data,
  output logic              bus_oe,
  output logic [ROWS-1:0]   row_sel,
  output logic [COLS-1:0]   col_sel
);
  logic [ROW_W-1:0]  row_bits;
  logic [DATA_W-1:0] rd_word;
  logic              wr_req;

  assign wr_req = cs && !rd_nwr;
  assign bus_oe = cs && rd_nwr;

  rcr_onehot_dec #(.IN_W(ROW_AW)) u_row_dec (
    .en  (cs),
    .idx (addr[ADDR_W-1:COL_AW]),
    .sel (row_sel)
  );

  rcr_onehot_dec #(.IN_W(COL_AW)) u_col_dec (
    .en  (cs),
    .idx (addr[COL_AW-1:0]),
    .sel (col_sel)
  );

  rcr_cell_array #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W)) u_cells (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_req),
    .row_en (row_sel),
    .col_en (col_sel),
    .wdata  (data),
    .rd_row (row_bits)
  );

  rcr_col_steer #(.COLS(COLS), .DATA_W(DATA_W)) u_steer (
    .row_data (row_bits),
    .col_en   (col_sel),
    .word     (rd_word)
  );

  assign data = bus_oe ? rd_word : 'z;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !cs |-> (row_sel == '0 && col_sel == '0 && !bus_oe)); // R6
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !rd_nwr |-> !bus_oe); // R7
  AST_READ_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> ($onehot(row_sel) && $onehot(col_sel))); // R2
endmodule

// File: tb/tb_rowcol_ram.sv
`timescale 1ns/1ps
module tb_rowcol_ram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] addr = '0;
  logic       cs = 1'b0;
  logic       rd_nwr = 1'b1;
  logic       tb_drv = 1'b0;
  logic [3:0] tb_val = '0;
  wire  [3:0] data;
  logic       bus_oe;
  logic [3:0] row_sel;
  logic [1:0] col_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int model [8];

  always #2 clk = ~clk;

  assign data = tb_drv ? tb_val : 'z;

  rowcol_ram dut (
    .clk(clk), .rst(rst), .addr(addr), .cs(cs), .rd_nwr(rd_nwr),
    .data(data), .bus_oe(bus_oe), .row_sel(row_sel), .col_sel(col_sel)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // One bus cycle: inputs applied after the rising edge, outputs compared at the falling edge.
  task automatic step(input int a, input bit sel, input bit rd, input int wv, input string tag);
    @(posedge clk); #1;
    addr = 3'(a); cs = sel; rd_nwr = rd;
    tb_drv = !rd; tb_val = 4'(wv);
    @(negedge clk);
    chk(sel ? (rd ? "R5 oe" : "R7 oe") : "R6 oe", int'(bus_oe), int'(sel && rd));
    chk(sel ? "R2 row" : "R6 row", int'(row_sel), sel ? (1 << (a >> 1)) : 0);
    chk(sel ? "R3 col" : "R6 col", int'(col_sel), sel ? (1 << (a & 1)) : 0);
    if (sel && rd) chk(tag, int'(data), model[a]);
    if (sel && !rd) model[a] = wv & 15;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; cs = 1'b0; rd_nwr = 1'b1; tb_drv = 1'b0;
    @(negedge clk);
    chk("R1 oe", int'(bus_oe), 0);
    chk("R1 row", int'(row_sel), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    foreach (model[i]) model[i] = 0;
  endtask

  initial begin
    foreach (model[i]) model[i] = 0;
    do_reset();
    for (int a = 0; a < 8; a++) step(a, 1, 1, 0, "R1 cleared");
    for (int a = 0; a < 8; a++) step(a, 1, 0, (a * 7 + 3) & 15, "R4");
    for (int a = 0; a < 8; a++) step(a, 1, 1, 0, "R4 readback");
    for (int a = 0; a < 8; a++) step(a, 0, 0, (~(a * 7 + 3)) & 15, "R6");
    for (int a = 7; a >= 0; a--) step(a, 1, 1, 0, "R6 unchanged");
    step(5, 1, 0, 0, "R4");
    step(4, 1, 1, 0, "R4 neighbour half");
    step(5, 1, 1, 0, "R4 overwrite");
    step(3, 1, 0, 12, "R4");
    step(3, 1, 1, 0, "R5 read after write");
    step(2, 1, 1, 0, "R4 neighbour half");
    step(6, 0, 1, 0, "R6");
    do_reset();
    for (int a = 0; a < 8; a++) step(a, 1, 1, 0, "R1 cleared again");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule